// File: doc/BRIEF.md
# Multi-Precision Banked Register File

This block is a local scratch store shared by several execution modules. It holds 32 bytes in four interleaved banks of eight byte-wide cells. Each attached module owns one read port and one write port. Every port picks, on each access, whether it works on single bytes, 16-bit pairs or 32-bit quads. Byte `b` lives in bank `b mod 4`, row `b div 4`. So an aligned quad spans all four banks in one row, and a pair spans two neighbouring banks.

Each port also carries an inclusive byte window, given as a low and a high byte index. The port may only touch bytes inside that window. Tight windows split the file into private partitions. Windows that overlap give two modules a shared mailbox through which one writes and the other reads. An access that leaves its window, names a register past the end of the file, or uses the unused size code is suppressed and flagged.

Reads and writes are both sampled on the rising clock edge. Read data and its fault flag appear in the register outputs one cycle after the address is presented. Writes land in the store at that same edge.

Top module: `mprf_top`

## Requirements
- R1: After reset every one of the 32 bytes reads as zero, and rd_data, rd_fault and wr_fault are all zero.
- R2: Size code 2'b00 selects a byte, 2'b01 a 16-bit pair and 2'b10 a 32-bit quad. Register number n at size s covers bytes n*span through n*span+span-1, where span is 1, 2 or 4. Byte order is little-endian: the lowest byte sits in data bits 7:0.
- R3: A byte read returns zero in rd_data bits 31:8, and a pair read returns zero in bits 31:16.
- R4: rd_data and rd_fault reflect the read request presented before the preceding rising edge (one-cycle read latency).
- R5: A write takes effect at the rising edge where it is presented. A read presented in the same cycle to the same bytes returns the value held before that write.
- R6: An access is legal only if all of its bytes lie within [win_lo, win_hi] inclusive for that port. A write that is not legal changes no byte. A read that is not legal returns zero data and raises rd_fault one cycle later.
- R7: Size code 2'b11 is always illegal, and so is a register number whose bytes run past byte 31. Both are suppressed and flagged as in R6.
- R8: When several ports write the same byte in one cycle, the lowest-numbered port's byte is stored. The bytes of a write that no lower port touches are still stored.
- R9: Data written by one port into a region that lies in the windows of two ports can be read by the other port on the following cycle.
- R10: wr_fault rises one cycle after a presented write that is illegal. It stays low in the cycle after a port presents no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_reg | input | NPORTS*5 | Register number per read port, in units of the chosen size |
| rd_size | input | NPORTS*2 | Size code per read port |
| rd_data | output | NPORTS*32 | Registered read data per port, zero-extended |
| rd_fault | output | NPORTS | Registered read suppression flag per port |
| wr_en | input | NPORTS | Write request per port |
| wr_reg | input | NPORTS*5 | Register number per write port |
| wr_size | input | NPORTS*2 | Size code per write port |
| wr_data | input | NPORTS*32 | Write data per port, little-endian, low bytes used for narrow sizes |
| wr_fault | output | NPORTS | Registered write suppression flag per port |
| win_lo | input | NPORTS*5 | Lowest byte index the port may touch |
| win_hi | input | NPORTS*5 | Highest byte index the port may touch |

## Verification
The bench targets three-port collisions on one byte where the writes are of different widths. A design that resolves priority per access instead of per byte, or that lets the higher port win, would leave the wrong mix of bytes in the quad read back afterwards. It also probes windows one byte too narrow for a quad, registers just past the file end and the unused size code. Checking the whole span against the window, instead of the first byte only, is what these cases test; a wrong check would let a write leak outside the partition or return stale non-zero data with no fault. Same-cycle read-after-write and the mailbox hand-off between overlapping windows catch a read path taken after the write mux, which would return the new value one cycle early.

// File: rtl/mprf_pkg.sv
package mprf_pkg;

    // access size codes shared by all ports
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_DUAL = 2'b01,
        SZ_QUAD = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;

    // widest access in bytes
    localparam int QUAD_BYTES = 4;

    // width of a span count (0..4)
    localparam int SPAN_W = 3;

endpackage

// File: rtl/mprf_window_check.sv
module mprf_window_check
    import mprf_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int NBYTES = 32
) (
    input  logic [IDX_W-1:0]  reg_num,
    input  logic [1:0]        size,
    input  logic [IDX_W-1:0]  win_lo,
    input  logic [IDX_W-1:0]  win_hi,
    output logic              legal,
    output logic [IDX_W-1:0]  first_byte,
    output logic [SPAN_W-1:0] span
);

    // extra headroom so that a shifted register number never wraps
    localparam int EXT_W = IDX_W + 3;
    localparam logic [EXT_W-1:0] ONE_X  = EXT_W'(1);
    localparam logic [EXT_W-1:0] TOP_X  = EXT_W'(NBYTES);

    logic [EXT_W-1:0] start_x;
    logic [EXT_W-1:0] last_x;

    always_comb begin
        span    = '0;
        start_x = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                span    = SPAN_W'(1);
                start_x = EXT_W'(reg_num);
            end
            SZ_DUAL: begin
                span    = SPAN_W'(2);
                start_x = EXT_W'(reg_num) << 1;
            end
            SZ_QUAD: begin
                span    = SPAN_W'(4);
                start_x = EXT_W'(reg_num) << 2;
            end
            default: begin
                span    = '0;
                start_x = '0;
            end
        endcase
        last_x     = start_x + EXT_W'(span) - ONE_X;
        legal      = (span != '0)
                  && (last_x < TOP_X)
                  && (start_x >= EXT_W'(win_lo))
                  && (last_x <= EXT_W'(win_hi));
        first_byte = start_x[IDX_W-1:0];
    end

endmodule

// File: rtl/mprf_bank.sv
module mprf_bank
    import mprf_pkg::*;
#(
    parameter int NPORTS  = 3,
    parameter int BYTE_W  = 8,
    parameter int ROWS    = 8,
    parameter int NBANKS  = 4,
    parameter int BANK_ID = 0,
    parameter int IDX_W   = 5,
    parameter int WORD_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        wr_go,
    input  logic [NPORTS*IDX_W-1:0]  wr_first,
    input  logic [NPORTS*SPAN_W-1:0] wr_span,
    input  logic [NPORTS*WORD_W-1:0] wr_word,
    output logic [ROWS*BYTE_W-1:0]   cells
);

    localparam int LANE_W = $clog2(NBANKS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int CMP_W  = LANE_W + SPAN_W;
    localparam logic [CMP_W-1:0] MY_LANE = CMP_W'(BANK_ID);

    logic [BYTE_W-1:0] cell_q [ROWS];
    logic [BYTE_W-1:0] cell_d [ROWS];

    logic [NPORTS-1:0] hit;
    logic [ROW_W-1:0]  row_of [NPORTS];
    logic [BYTE_W-1:0] val_of [NPORTS];

    // per-port decode: does this port's access cover this bank, and which byte lane
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [IDX_W-1:0]  first;
        logic [CMP_W-1:0]  lane_lo;
        logic [CMP_W-1:0]  lane_end;
        logic [CMP_W-1:0]  lane_off;
        logic [WORD_W-1:0] word;

        assign first     = wr_first[p*IDX_W +: IDX_W];
        assign lane_lo   = CMP_W'(first[LANE_W-1:0]);
        assign lane_end  = lane_lo + CMP_W'(wr_span[p*SPAN_W +: SPAN_W]);
        assign lane_off  = MY_LANE - lane_lo;
        assign word      = wr_word[p*WORD_W +: WORD_W];
        assign hit[p]    = wr_go[p] && (MY_LANE >= lane_lo) && (MY_LANE < lane_end);
        assign row_of[p] = first[IDX_W-1:LANE_W];
        assign val_of[p] = BYTE_W'(word >> (int'(lane_off) * BYTE_W));
    end

    // highest port applied first so the lowest-numbered port lands last
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            cell_d[r] = cell_q[r];
        end
        for (int p = NPORTS - 1; p >= 0; p--) begin
            if (hit[p]) begin
                cell_d[row_of[p]] = val_of[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cell_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                cell_q[r] <= cell_d[r];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_out
        assign cells[r*BYTE_W +: BYTE_W] = cell_q[r];
    end

endmodule

// File: rtl/mprf_read_port.sv
module mprf_read_port
    import mprf_pkg::*;
#(
    parameter int NBYTES = 32,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBYTES*BYTE_W-1:0] store,
    input  logic                     legal,
    input  logic [IDX_W-1:0]         first_byte,
    input  logic [SPAN_W-1:0]        span,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_fault
);

    logic [WORD_W-1:0] gathered;

    // gather span bytes starting at first_byte, lowest byte into lane 0
    always_comb begin
        gathered = '0;
        for (int k = 0; k < QUAD_BYTES; k++) begin
            if (legal && (k < int'(span))) begin
                gathered[k*BYTE_W +: BYTE_W] =
                    BYTE_W'(store >> ((int'(first_byte) + k) * BYTE_W));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_fault <= 1'b0;
        end else begin
            rd_data  <= gathered;
            rd_fault <= !legal;
        end
    end

endmodule

// File: rtl/mprf_top.sv
module mprf_top
    import mprf_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int BYTE_W = 8,
    parameter int NBANKS = 4,
    parameter int ROWS   = 8,
    localparam int NBYTES = NBANKS * ROWS,
    localparam int IDX_W  = $clog2(NBYTES),
    localparam int WORD_W = QUAD_BYTES * BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS*IDX_W-1:0]  rd_reg,
    input  logic [NPORTS*2-1:0]      rd_size,
    output logic [NPORTS*WORD_W-1:0] rd_data,
    output logic [NPORTS-1:0]        rd_fault,
    input  logic [NPORTS-1:0]        wr_en,
    input  logic [NPORTS*IDX_W-1:0]  wr_reg,
    input  logic [NPORTS*2-1:0]      wr_size,
    input  logic [NPORTS*WORD_W-1:0] wr_data,
    output logic [NPORTS-1:0]        wr_fault,
    input  logic [NPORTS*IDX_W-1:0]  win_lo,
    input  logic [NPORTS*IDX_W-1:0]  win_hi
);

    logic [NPORTS-1:0]        rd_ok;
    logic [NPORTS*IDX_W-1:0]  rd_first;
    logic [NPORTS*SPAN_W-1:0] rd_span;

    logic [NPORTS-1:0]        wr_ok;
    logic [NPORTS-1:0]        wr_go;
    logic [NPORTS*IDX_W-1:0]  wr_first;
    logic [NPORTS*SPAN_W-1:0] wr_span;

    logic [ROWS*BYTE_W-1:0]   bank_cells [NBANKS];
    logic [NBYTES*BYTE_W-1:0] store;
    logic [NPORTS-1:0]        wr_fault_q;

    // window and range checks, one pair per port
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        mprf_window_check #(
            .IDX_W (IDX_W),
            .NBYTES(NBYTES)
        ) i_rd_chk (
            .reg_num   (rd_reg[p*IDX_W +: IDX_W]),
            .size      (rd_size[p*2 +: 2]),
            .win_lo    (win_lo[p*IDX_W +: IDX_W]),
            .win_hi    (win_hi[p*IDX_W +: IDX_W]),
            .legal     (rd_ok[p]),
            .first_byte(rd_first[p*IDX_W +: IDX_W]),
            .span      (rd_span[p*SPAN_W +: SPAN_W])
        );

        mprf_window_check #(
            .IDX_W (IDX_W),
            .NBYTES(NBYTES)
        ) i_wr_chk (
            .reg_num   (wr_reg[p*IDX_W +: IDX_W]),
            .size      (wr_size[p*2 +: 2]),
            .win_lo    (win_lo[p*IDX_W +: IDX_W]),
            .win_hi    (win_hi[p*IDX_W +: IDX_W]),
            .legal     (wr_ok[p]),
            .first_byte(wr_first[p*IDX_W +: IDX_W]),
            .span      (wr_span[p*SPAN_W +: SPAN_W])
        );
    end

    assign wr_go = wr_en & wr_ok;

    // interleaved banks: byte b sits in bank b mod NBANKS, row b div NBANKS
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        mprf_bank #(
            .NPORTS (NPORTS),
            .BYTE_W (BYTE_W),
            .ROWS   (ROWS),
            .NBANKS (NBANKS),
            .BANK_ID(b),
            .IDX_W  (IDX_W),
            .WORD_W (WORD_W)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_go   (wr_go),
            .wr_first(wr_first),
            .wr_span (wr_span),
            .wr_word (wr_data),
            .cells   (bank_cells[b])
        );
    end

    // flatten to byte-index order for the read side
    for (genvar i = 0; i < NBYTES; i++) begin : g_flat
        assign store[i*BYTE_W +: BYTE_W] =
            bank_cells[i % NBANKS][(i / NBANKS)*BYTE_W +: BYTE_W];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        mprf_read_port #(
            .NBYTES(NBYTES),
            .BYTE_W(BYTE_W),
            .IDX_W (IDX_W),
            .WORD_W(WORD_W)
        ) i_rd (
            .clk       (clk),
            .rst_n     (rst_n),
            .store     (store),
            .legal     (rd_ok[p]),
            .first_byte(rd_first[p*IDX_W +: IDX_W]),
            .span      (rd_span[p*SPAN_W +: SPAN_W]),
            .rd_data   (rd_data[p*WORD_W +: WORD_W]),
            .rd_fault  (rd_fault[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_fault_q <= '0;
        end else begin
            wr_fault_q <= wr_en & ~wr_ok;
        end
    end

    assign wr_fault = wr_fault_q;

endmodule

// File: rtl/mprf_checker.sv
module mprf_checker #(
    parameter int NPORTS = 3,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    parameter int WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORTS*IDX_W-1:0]  rd_reg,
    input logic [NPORTS*2-1:0]      rd_size,
    input logic [NPORTS*WORD_W-1:0] rd_data,
    input logic [NPORTS-1:0]        rd_fault,
    input logic [NPORTS-1:0]        wr_en,
    input logic [NPORTS-1:0]        wr_fault
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_prop
        AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_fault[p] |-> (rd_data[p*WORD_W +: WORD_W] == '0)); // R6

        AST_NONE_SIZE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_size[p*2 +: 2] == 2'b11) |=> rd_fault[p]); // R7

        AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_size[p*2 +: 2] == 2'b00) |=> (rd_data[p*WORD_W + BYTE_W +: WORD_W - BYTE_W] == '0)); // R3

        AST_DUAL_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_size[p*2 +: 2] == 2'b01) |=> (rd_data[p*WORD_W + 2*BYTE_W +: WORD_W - 2*BYTE_W] == '0)); // R3

        AST_IDLE_NO_WFAULT: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[p] |=> !wr_fault[p]); // R10
    end

endmodule

bind mprf_top mprf_checker #(
    .NPORTS(NPORTS),
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W),
    .WORD_W(WORD_W)
) i_mprf_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_reg  (rd_reg),
    .rd_size (rd_size),
    .rd_data (rd_data),
    .rd_fault(rd_fault),
    .wr_en   (wr_en),
    .wr_fault(wr_fault)
);

// File: tb/test_mprf_top.sv
module test_mprf_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 3;
    localparam int IW  = 5;
    localparam int WW  = 32;
    localparam int NBY = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [NP*IW-1:0] rd_reg_bus, wr_reg_bus, lo_bus, hi_bus;
    logic [NP*2-1:0]  rd_size_bus, wr_size_bus;
    logic [NP*WW-1:0] rd_data_bus, wr_data_bus;
    logic [NP-1:0]    rd_fault_bus, wr_fault_bus, wr_en_bus;

    logic [IW-1:0] ra [NP];
    logic [1:0]    rs [NP];
    logic          we [NP];
    logic [IW-1:0] wa [NP];
    logic [1:0]    wsz [NP];
    logic [WW-1:0] wd [NP];
    logic [IW-1:0] wlo [NP];
    logic [IW-1:0] whi [NP];

    int total = 0;
    int bad = 0;
    int mem [NBY];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            rd_reg_bus[p*IW +: IW]  = ra[p];
            rd_size_bus[p*2 +: 2]   = rs[p];
            wr_en_bus[p]            = we[p];
            wr_reg_bus[p*IW +: IW]  = wa[p];
            wr_size_bus[p*2 +: 2]   = wsz[p];
            wr_data_bus[p*WW +: WW] = wd[p];
            lo_bus[p*IW +: IW]      = wlo[p];
            hi_bus[p*IW +: IW]      = whi[p];
        end
    end

    mprf_top i_mprf_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_reg  (rd_reg_bus),
        .rd_size (rd_size_bus),
        .rd_data (rd_data_bus),
        .rd_fault(rd_fault_bus),
        .wr_en   (wr_en_bus),
        .wr_reg  (wr_reg_bus),
        .wr_size (wr_size_bus),
        .wr_data (wr_data_bus),
        .wr_fault(wr_fault_bus),
        .win_lo  (lo_bus),
        .win_hi  (hi_bus)
    );

    task automatic check(input string tag, input string what, input int p,
                         input logic [WW-1:0] got, input logic [WW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s port%0d: got %h expected %h", tag, what, p, got, exp);
        end
    endtask

    // reference legality: span from size code, bytes inside file and window
    function automatic bit m_legal(input int a, input int sz, input int lo, input int hi,
                                   output int first, output int n);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        first = a * n;
        if (n == 0) return 1'b0;
        return (first + n - 1 < NBY) && (first >= lo) && (first + n - 1 <= hi);
    endfunction

    // one clock: predict from the model, advance, compare after the edge
    task automatic step(input string tag);
        logic [WW-1:0] e_rd [NP];
        logic          e_rf [NP];
        logic          e_wf [NP];
        int f, n;
        bit ok;
        for (int p = 0; p < NP; p++) begin
            ok = m_legal(int'(ra[p]), int'(rs[p]), int'(wlo[p]), int'(whi[p]), f, n);
            e_rd[p] = '0;
            e_rf[p] = !ok;
            if (ok) begin
                for (int k = 0; k < n; k++) e_rd[p][k*8 +: 8] = 8'(mem[f+k]);
            end
        end
        for (int p = NP - 1; p >= 0; p--) begin
            ok = m_legal(int'(wa[p]), int'(wsz[p]), int'(wlo[p]), int'(whi[p]), f, n);
            e_wf[p] = we[p] && !ok;
            if (we[p] && ok) begin
                for (int k = 0; k < n; k++) mem[f+k] = int'(wd[p][k*8 +: 8]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            check(tag, "rd_data", p, rd_data_bus[p*WW +: WW], e_rd[p]);
            check(tag, "rd_fault", p, WW'(rd_fault_bus[p]), WW'(e_rf[p]));
            check(tag, "wr_fault", p, WW'(wr_fault_bus[p]), WW'(e_wf[p]));
        end
    endtask

    task automatic idle_all();
        for (int p = 0; p < NP; p++) begin
            ra[p] = '0; rs[p] = 2'b00; we[p] = 1'b0;
            wa[p] = '0; wsz[p] = 2'b00; wd[p] = '0;
        end
    endtask

    task automatic full_windows();
        for (int p = 0; p < NP; p++) begin
            wlo[p] = 5'd0; whi[p] = 5'd31;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBY; i++) mem[i] = 0;
        idle_all();
        full_windows();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the outputs
        for (int p = 0; p < NP; p++) begin
            check("R1", "rd_data", p, rd_data_bus[p*WW +: WW], '0);
            check("R1", "rd_fault", p, WW'(rd_fault_bus[p]), '0);
            check("R1", "wr_fault", p, WW'(wr_fault_bus[p]), '0);
        end
        // R1: every quad reads zero
        for (int q = 0; q < 8; q += NP) begin
            for (int p = 0; p < NP; p++) begin
                ra[p] = 5'((q + p) % 8); rs[p] = 2'b10;
            end
            step("R1");
        end
        // R2: byte writes from port0, byte reads trail on port1
        idle_all();
        for (int i = 0; i < NBY; i++) begin
            we[0] = 1'b1; wa[0] = 5'(i); wsz[0] = 2'b00; wd[0] = 32'hFFFF_FF00 | 32'(8'hA0 + 8'(i));
            ra[1] = 5'((i + NBY - 1) % NBY); rs[1] = 2'b00;
            step("R2");
        end
        idle_all();
        // R2 R3: read back at all three sizes
        for (int i = 0; i < 16; i++) begin
            ra[0] = 5'(i); rs[0] = 2'b01;
            ra[1] = 5'(i % 8); rs[1] = 2'b10;
            ra[2] = 5'(i * 2); rs[2] = 2'b00;
            step("R3");
        end
        // R2: quad write, little-endian view through narrow reads
        we[2] = 1'b1; wa[2] = 5'd3; wsz[2] = 2'b10; wd[2] = 32'h4433_2211;
        step("R2");
        idle_all();
        ra[0] = 5'd12; rs[0] = 2'b00;
        ra[1] = 5'd7;  rs[1] = 2'b01;
        ra[2] = 5'd15; rs[2] = 2'b00;
        step("R2");
        // R4 R5: same-cycle read of a byte being written returns old value
        we[0] = 1'b1; wa[0] = 5'd7; wsz[0] = 2'b00; wd[0] = 32'h0000_005A;
        ra[1] = 5'd7; rs[1] = 2'b00;
        ra[2] = 5'd1; rs[2] = 2'b10;
        step("R5");
        we[0] = 1'b0;
        step("R4");
        // R6: port1 confined to bytes 8..15
        wlo[1] = 5'd8; whi[1] = 5'd15;
        we[1] = 1'b1; wa[1] = 5'd20; wsz[1] = 2'b00; wd[1] = 32'h0000_00EE;
        ra[1] = 5'd4; rs[1] = 2'b10;
        step("R6");
        we[1] = 1'b1; wa[1] = 5'd2; wsz[1] = 2'b10; wd[1] = 32'hDDCC_BBAA;
        ra[1] = 5'd2; rs[1] = 2'b10;
        step("R6");
        wlo[1] = 5'd9;
        we[1] = 1'b1; wa[1] = 5'd2; wsz[1] = 2'b10; wd[1] = 32'h1357_9BDF;
        ra[1] = 5'd2; rs[1] = 2'b10;
        ra[0] = 5'd20; rs[0] = 2'b00;
        step("R6");
        we[1] = 1'b1; wa[1] = 5'd7; wsz[1] = 2'b01; wd[1] = 32'h0000_7766;
        ra[1] = 5'd16; rs[1] = 2'b00;
        ra[0] = 5'd2; rs[0] = 2'b10;
        step("R6");
        we[1] = 1'b0; ra[1] = 5'd7; rs[1] = 2'b01;
        step("R6");
        full_windows();
        idle_all();
        // R7: unused size code and registers past the end
        rs[0] = 2'b11; ra[0] = 5'd0;
        ra[1] = 5'd16; rs[1] = 2'b01;
        ra[2] = 5'd8;  rs[2] = 2'b10;
        we[0] = 1'b1; wa[0] = 5'd0; wsz[0] = 2'b11; wd[0] = 32'hFFFF_FFFF;
        we[1] = 1'b1; wa[1] = 5'd31; wsz[1] = 2'b01; wd[1] = 32'h0000_9999;
        we[2] = 1'b1; wa[2] = 5'd9; wsz[2] = 2'b10; wd[2] = 32'h8888_8888;
        step("R7");
        idle_all();
        ra[0] = 5'd0; rs[0] = 2'b10;
        ra[1] = 5'd7; rs[1] = 2'b10;
        step("R7");
        // R10: no write after a fault leaves wr_fault low
        step("R10");
        // R8: three ports collide on bytes 4..7
        we[0] = 1'b1; wa[0] = 5'd5; wsz[0] = 2'b00; wd[0] = 32'h0000_0055;
        we[1] = 1'b1; wa[1] = 5'd1; wsz[1] = 2'b10; wd[1] = 32'h1111_1111;
        we[2] = 1'b1; wa[2] = 5'd2; wsz[2] = 2'b01; wd[2] = 32'h0000_2222;
        step("R8");
        idle_all();
        ra[0] = 5'd1; rs[0] = 2'b10;
        step("R8");
        // R8: partial overlap, higher port keeps the bytes lower ports leave alone
        we[0] = 1'b1; wa[0] = 5'd9; wsz[0] = 2'b00; wd[0] = 32'h0000_0009;
        we[2] = 1'b1; wa[2] = 5'd2; wsz[2] = 2'b10; wd[2] = 32'hA3A2_A1A0;
        step("R8");
        idle_all();
        ra[2] = 5'd2; rs[2] = 2'b10;
        step("R8");
        // R9: overlapping windows used as a mailbox
        wlo[1] = 5'd0;  whi[1] = 5'd15;
        wlo[2] = 5'd12; whi[2] = 5'd31;
        we[1] = 1'b1; wa[1] = 5'd3; wsz[1] = 2'b10; wd[1] = 32'hCAFE_F00D;
        step("R9");
        we[1] = 1'b0;
        ra[2] = 5'd3; rs[2] = 2'b10;
        we[2] = 1'b1; wa[2] = 5'd14; wsz[2] = 2'b00; wd[2] = 32'h0000_0042;
        step("R9");
        we[2] = 1'b0;
        ra[1] = 5'd14; rs[1] = 2'b00;
        step("R9");
        // mixed random traffic
        for (int c = 0; c < 400; c++) begin
            for (int p = 0; p < NP; p++) begin
                logic [4:0] a, b;
                a = 5'($urandom); b = 5'($urandom);
                if ((c % 4) == 0) begin a = 5'd0; b = 5'd31; end
                wlo[p] = (a < b) ? a : b;
                whi[p] = (a < b) ? b : a;
                ra[p] = 5'($urandom); rs[p] = 2'($urandom);
                we[p] = 1'($urandom); wa[p] = 5'($urandom % 8);
                wsz[p] = 2'($urandom); wd[p] = $urandom;
            end
            step("R2 R6 R8 mix");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule